// File: doc/BRIEF.md
# GPIO Edge Interrupt Unit with Banked Outputs

This block turns transitions on already-synchronized general-purpose inputs into interrupt requests. Every pin carries two independent enables, one for rising transitions and one for falling transitions. A detected edge on an enabled pin latches a per-pin status bit. That bit stays set until software clears it by writing a one to its position.

The status bits are grouped into banks of 16 pins. Each bank drives one level-sensitive interrupt line, and one bit of a bank-enable register gates that line. Software reaches the block through a simple register slave: a single-cycle write strobe with a byte address and 32-bit data, and a combinational read-data path. A direct mode can also be selected. In direct mode the first few pins each drive their own interrupt line from their status bit, so that an external interrupt controller can service them without going through the bank lines.

Top module: `gpio_eint_top`

## Requirements
- R1: While reset is asserted and right after it is released, every rising enable, falling enable, status bit and bank-enable bit reads 0, and every bank and direct interrupt output is low.
- R2: A 0-to-1 transition on a pin whose rising enable is set sets that pin's status bit (bit i of the status word at offset 0x20) at the clock edge where the new level is first sampled.
- R3: A 1-to-0 transition on a pin whose falling enable is set sets that pin's status bit at the clock edge where the new level is first sampled.
- R4: When both enables of a pin are set, a transition in either direction sets its status bit.
- R5: Enables change only through dedicated registers, with bit i meaning pin i. A write to offset 0x10 sets, and a write to 0x14 clears, the rising enables of the pins written as 1. Offsets 0x18 and 0x1C do the same for the falling enables. Zero bits leave enables untouched. Reading 0x10 or 0x14 returns the rising enables, and reading 0x18 or 0x1C returns the falling enables.
- R6: Writing to the status word at 0x20 clears exactly the bits written as 1. Bits written as 0 are unaffected, and writing back the value just read clears all of those bits.
- R7: If a new edge and a clearing write hit the same status bit in the same cycle, the bit stays set.
- R8: Status bits 15:0 form bank 0 and bits 31:16 form bank 1. Bank interrupt output n is high while any status bit of bank n is set and its bank-enable bit is set.
- R9: The bank-enable register sits at offset 0x08, and bit n gates bank n. Clearing bit n drops bank n's output, but its status bits stay latched and readable.
- R10: When direct_mode_i is 1, direct interrupt output i (for the first DIRECT_PINS pins) follows status bit i. When direct_mode_i is 0, every direct output is low.
- R11: A transition on a pin whose enable for that direction is clear leaves the status word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| pin_i | input | 32 | Synchronized GPIO input levels |
| wr_en_i | input | 1 | Register write strobe, one cycle per write |
| addr_i | input | 8 | Register byte address |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Combinational read data for addr_i |
| direct_mode_i | input | 1 | Selects the per-pin direct interrupt lines |
| bank_irq_o | output | 2 | Level interrupt, one per 16-pin bank |
| pin_irq_o | output | 8 | Direct per-pin interrupt lines |

## Verification
An edge or a register write applied before clock edge k shows up in the status word, the enables and the bank lines right after edge k. Nothing else sits in that path: there is one register stage between the pins and the status bits, and the bank and direct lines are combinational from the registers. The bench therefore drives each stimulus on the falling clock edge. It lets exactly one rising edge pass, then samples the read data and the interrupt outputs shortly after the next falling edge. The bank-enable gate and the direct-mode select act combinationally, so their checks are taken within the same half cycle, with no clock edge in between.

// File: rtl/gpio_eint_pkg.sv
package gpio_eint_pkg;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned DATA_W = 32;

  // register byte offsets
  localparam logic [ADDR_W-1:0] OFF_BANK_EN  = 8'h08;
  localparam logic [ADDR_W-1:0] OFF_RISE_SET = 8'h10;
  localparam logic [ADDR_W-1:0] OFF_RISE_CLR = 8'h14;
  localparam logic [ADDR_W-1:0] OFF_FALL_SET = 8'h18;
  localparam logic [ADDR_W-1:0] OFF_FALL_CLR = 8'h1C;
  localparam logic [ADDR_W-1:0] OFF_STATUS   = 8'h20;
endpackage

// File: rtl/gpio_eint_edge.sv
// Per-pin edge detector: compares the input with its copy from the last clock.
module gpio_eint_edge #(
  parameter int unsigned NPINS = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NPINS-1:0] pin_i,
  input  logic [NPINS-1:0] rise_en_i,
  input  logic [NPINS-1:0] fall_en_i,
  output logic [NPINS-1:0] edge_o
);
  logic [NPINS-1:0] prev_q, prev_d;
  logic             prev_ce;

  always_comb begin
    prev_ce = 1'b1;
    prev_d  = pin_i;
    edge_o  = (pin_i & ~prev_q & rise_en_i) | (~pin_i & prev_q & fall_en_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      prev_q <= '0;
    else if (prev_ce) prev_q <= prev_d;
  end

  // R11: an edge is only reported on an enabled direction
  p_edge_enabled_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((edge_o & ~(rise_en_i | fall_en_i)) == '0));
endmodule

// File: rtl/gpio_eint_cfg.sv
// Edge enable and bank enable registers with set/clear write ports.
module gpio_eint_cfg
  import gpio_eint_pkg::*;
#(
  parameter int unsigned NPINS  = 32,
  parameter int unsigned NBANKS = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [NPINS-1:0]  rise_en_o,
  output logic [NPINS-1:0]  fall_en_o,
  output logic [NBANKS-1:0] bank_en_o
);
  logic [NPINS-1:0]  rise_q, rise_d, fall_q, fall_d;
  logic [NBANKS-1:0] bank_q, bank_d;
  logic              rise_ce, fall_ce, bank_ce;
  logic [NPINS-1:0]  wmask;

  always_comb begin
    wmask   = wdata_i[NPINS-1:0];
    rise_ce = wr_en_i && (addr_i == OFF_RISE_SET || addr_i == OFF_RISE_CLR);
    fall_ce = wr_en_i && (addr_i == OFF_FALL_SET || addr_i == OFF_FALL_CLR);
    bank_ce = wr_en_i && (addr_i == OFF_BANK_EN);
    rise_d  = (addr_i == OFF_RISE_SET) ? (rise_q | wmask) : (rise_q & ~wmask);
    fall_d  = (addr_i == OFF_FALL_SET) ? (fall_q | wmask) : (fall_q & ~wmask);
    bank_d  = wdata_i[NBANKS-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rise_q <= '0;
      fall_q <= '0;
      bank_q <= '0;
    end else begin
      if (rise_ce) rise_q <= rise_d;
      if (fall_ce) fall_q <= fall_d;
      if (bank_ce) bank_q <= bank_d;
    end
  end

  assign rise_en_o = rise_q;
  assign fall_en_o = fall_q;
  assign bank_en_o = bank_q;

  // R5: enables hold unless a register write occurs
  p_en_stable_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> ($stable(rise_q) && $stable(fall_q) && $stable(bank_q)));
endmodule

// File: rtl/gpio_eint_status.sv
// Sticky status bits: set by edges, cleared by write-one-to-clear; edge wins.
module gpio_eint_status #(
  parameter int unsigned NPINS = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NPINS-1:0] set_i,
  input  logic [NPINS-1:0] clr_i,
  output logic [NPINS-1:0] status_o
);
  logic [NPINS-1:0] st_q, st_d;
  logic             st_ce;

  always_comb begin
    st_ce = (set_i != '0) || (clr_i != '0);
    st_d  = (st_q & ~clr_i) | set_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    st_q <= '0;
    else if (st_ce) st_q <= st_d;
  end

  assign status_o = st_q;

  for (genvar i = 0; i < NPINS; i++) begin : g_chk
    // R6: a set bit survives any cycle without a clear on it
    p_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_q[i] && !clr_i[i]) |=> st_q[i]);
    // R2: a bit only rises after an edge was reported
    p_rise_cause_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(st_q[i]) |-> $past(set_i[i]));
    // R7: simultaneous edge and clear leaves the bit set
    p_edge_wins_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (set_i[i] && clr_i[i]) |=> st_q[i]);
  end
endmodule

// File: rtl/gpio_eint_top.sv
module gpio_eint_top
  import gpio_eint_pkg::*;
#(
  parameter int unsigned NPINS       = 32,
  parameter int unsigned BANK_W      = 16,
  parameter int unsigned DIRECT_PINS = 8,
  localparam int unsigned NBANKS     = NPINS / BANK_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NPINS-1:0]  pin_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              direct_mode_i,
  output logic [NBANKS-1:0] bank_irq_o,
  output logic [DIRECT_PINS-1:0] pin_irq_o
);
  logic [NPINS-1:0]  rise_en, fall_en, edges, status, st_clr;
  logic [NBANKS-1:0] bank_en;

  gpio_eint_cfg #(.NPINS(NPINS), .NBANKS(NBANKS)) cfg_i (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i,
    .rise_en_o(rise_en), .fall_en_o(fall_en), .bank_en_o(bank_en)
  );

  gpio_eint_edge #(.NPINS(NPINS)) edge_i (
    .clk_i, .rst_ni, .pin_i,
    .rise_en_i(rise_en), .fall_en_i(fall_en), .edge_o(edges)
  );

  assign st_clr = (wr_en_i && addr_i == OFF_STATUS) ? wdata_i[NPINS-1:0] : '0;

  gpio_eint_status #(.NPINS(NPINS)) stat_i (
    .clk_i, .rst_ni, .set_i(edges), .clr_i(st_clr), .status_o(status)
  );

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      OFF_BANK_EN:                rdata_o[NBANKS-1:0] = bank_en;
      OFF_RISE_SET, OFF_RISE_CLR: rdata_o[NPINS-1:0]  = rise_en;
      OFF_FALL_SET, OFF_FALL_CLR: rdata_o[NPINS-1:0]  = fall_en;
      OFF_STATUS:                 rdata_o[NPINS-1:0]  = status;
      default:                    rdata_o = '0;
    endcase
  end

  for (genvar b = 0; b < NBANKS; b++) begin : g_bank
    assign bank_irq_o[b] = bank_en[b] && (status[b*BANK_W +: BANK_W] != '0);
    // R8: a bank line only drops after a write (clear or bank disable)
    p_bank_drop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(bank_irq_o[b]) |-> $past(wr_en_i));
  end

  for (genvar d = 0; d < DIRECT_PINS; d++) begin : g_direct
    assign pin_irq_o[d] = direct_mode_i && status[d];
  end

  // R10: direct lines are quiet outside direct mode
  p_direct_off_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !direct_mode_i |-> (pin_irq_o == '0));
endmodule

// File: tb/gpio_eint_top_tb_top.sv
module gpio_eint_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] pins;
  logic        wr_en;
  logic [7:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        dmode;
  logic [1:0]  bank_irq;
  logic [7:0]  pin_irq;
  int vectors = 0;
  int miscompares = 0;

  always #4 clk = ~clk;

  gpio_eint_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pins), .wr_en_i(wr_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .direct_mode_i(dmode), .bank_irq_o(bank_irq), .pin_irq_o(pin_irq)
  );

  typedef struct packed {
    logic        is_wr;
    logic [7:0]  a;
    logic [31:0] d;
    logic [31:0] exp_st;
    logic [1:0]  exp_bank;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 8'h08, 32'h3,        32'h0,        2'b00}, // R9 enable both banks
    '{1'b0, 8'h00, 32'h1,        32'h0,        2'b00}, // R11 rise, not enabled
    '{1'b0, 8'h00, 32'h0,        32'h0,        2'b00}, // R11 fall, not enabled
    '{1'b1, 8'h10, 32'h00010001, 32'h0,        2'b00}, // R5 rise set pins 0,16
    '{1'b0, 8'h00, 32'h1,        32'h1,        2'b01}, // R2 pin0 rise
    '{1'b0, 8'h00, 32'h00010001, 32'h00010001, 2'b11}, // R8 pin16 -> bank1
    '{1'b0, 8'h00, 32'h0,        32'h00010001, 2'b11}, // R11 falls ignored
    '{1'b1, 8'h20, 32'h1,        32'h00010000, 2'b10}, // R6 clear bit0 only
    '{1'b1, 8'h18, 32'h2,        32'h00010000, 2'b10}, // R5 fall set pin1
    '{1'b0, 8'h00, 32'h2,        32'h00010000, 2'b10}, // R11 pin1 rise ignored
    '{1'b0, 8'h00, 32'h0,        32'h00010002, 2'b11}, // R3 pin1 fall
    '{1'b1, 8'h08, 32'h1,        32'h00010002, 2'b01}, // R9 bank1 gated, latched
    '{1'b1, 8'h20, 32'h00010002, 32'h0,        2'b00}, // R6 write back read value
    '{1'b1, 8'h10, 32'h4,        32'h0,        2'b00}, // R5 rise set pin2
    '{1'b1, 8'h18, 32'h4,        32'h0,        2'b00}, // R5 fall set pin2
    '{1'b0, 8'h00, 32'h4,        32'h4,        2'b01}, // R4 both: rise
    '{1'b1, 8'h20, 32'h4,        32'h0,        2'b00}, // R6 clear
    '{1'b0, 8'h00, 32'h0,        32'h4,        2'b01}, // R4 both: fall
    '{1'b1, 8'h14, 32'h4,        32'h4,        2'b01}, // R5 rise clear pin2
    '{1'b1, 8'h20, 32'h4,        32'h0,        2'b00}, // R6 clear
    '{1'b0, 8'h00, 32'h4,        32'h0,        2'b00}  // R5 cleared rise ignored
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(logic [7:0] a, string req, logic [31:0] exp);
    addr = a;
    #1 chk(req, rdata, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    rst_n = 1'b0; pins = '0; wr_en = 1'b0; addr = 8'h20; wdata = '0; dmode = 1'b0;
    repeat (3) @(negedge clk);
    // R1 during reset
    rd(8'h20, "R1 status", 32'h0);
    chk("R1 bank_irq", {30'h0, bank_irq}, 32'h0);
    chk("R1 pin_irq", {24'h0, pin_irq}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    rd(8'h10, "R1 rise en", 32'h0);
    rd(8'h18, "R1 fall en", 32'h0);
    rd(8'h08, "R1 bank en", 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].is_wr) begin
        wr_en = 1'b1; addr = VECS[i].a; wdata = VECS[i].d;
      end else begin
        pins = VECS[i].d;
      end
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0;
      rd(8'h20, $sformatf("vec%0d status", i), VECS[i].exp_st);
      chk($sformatf("vec%0d bank_irq", i), {30'h0, bank_irq}, {30'h0, VECS[i].exp_bank});
    end

    // R5 readback through both offsets
    rd(8'h10, "R5 rise read set", 32'h00010001);
    rd(8'h14, "R5 rise read clr", 32'h00010001);
    rd(8'h1C, "R5 fall read clr", 32'h6);
    rd(8'h08, "R9 bank en read", 32'h1);

    // R7 edge on pin0 and clear of bit0 in the same cycle
    pins = 32'h5; wr_en = 1'b1; addr = 8'h20; wdata = 32'h1;
    @(posedge clk); @(negedge clk); wr_en = 1'b0;
    rd(8'h20, "R7 edge beats clear", 32'h1);

    // R10 direct lines
    chk("R10 mode off", {24'h0, pin_irq}, 32'h0);
    dmode = 1'b1;
    #1 chk("R10 mode on", {24'h0, pin_irq}, 32'h1);
    dmode = 1'b0;
    #1 chk("R10 mode off again", {24'h0, pin_irq}, 32'h0);

    // R1 reset mid-run
    rst_n = 1'b0;
    @(negedge clk);
    rd(8'h20, "R1 status after reset", 32'h0);
    chk("R1 bank_irq after reset", {30'h0, bank_irq}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    rd(8'h10, "R1 rise after reset", 32'h0);

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule